// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block is the mode state machine of one digital PLL channel. It decides whether the channel runs free from the system clock, tracks its selected reference (locked), or holds its last frequency (holdover). The channel reads the one-hot mode output and the holdover-entry pulse to decide when to freeze its frequency word. Qualifying references, loop arithmetic and holdover averaging are done elsewhere.

A 3-bit mode code picks automatic operation or forces one of the three modes. In automatic operation the machine starts in free-run. It locks when the reference selector reports a selected input clock. It falls into holdover only when the locked reference is lost through one of three selector events. From holdover it either re-locks or, when no input clock is selected, drops back to free-run. A power-down bit, set by default, parks the channel in free-run. All pins are plain control and status signals with no stream handshake. Every output is registered and reflects the inputs sampled at the previous rising edge.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the output shows free-run (`mode_onehot` = 3'b001) and `hold_entry` is 0.
- R2: When `pwr_down` is 1 at a rising edge, the next cycle shows free-run with `hold_entry` 0, whatever the mode code and the other inputs.
- R3: `mode_onehot` always has exactly one bit set: bit 0 is free-run, bit 1 is locked and bit 2 is holdover.
- R4: In automatic operation, free-run moves to locked on the edge after `ref_selected` is seen high.
- R5: In automatic free-run with `ref_selected` low, the three event strobes have no effect and the mode stays free-run.
- R6: In automatic locked mode, any one of `evt_disqual`, `evt_prio_switch` or `evt_forced_switch` moves the machine to holdover on the next edge.
- R7: In automatic locked mode with no event, the machine stays locked, even if `ref_selected` is low.
- R8: In automatic holdover, the next mode is locked if `ref_selected` is high and free-run otherwise.
- R9: Mode code 3'b001 forces free-run, 3'b010 forces holdover and 3'b100 forces locked on the next edge. Code 3'b000 and every unlisted code (3'b011, 3'b101, 3'b110, 3'b111) select automatic operation.
- R10: `hold_entry` is high for exactly one cycle, in the first cycle of each holdover period, whether that period was entered automatically or by a forced code.
- R11: On a change from a forced code to automatic, the automatic machine continues from the forced mode without an extra transition and without a `hold_entry` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 3 | Automatic or forced mode selection |
| pwr_down | input | 1 | 1 parks the channel in free-run |
| ref_selected | input | 1 | An input clock is currently selected |
| evt_disqual | input | 1 | Strobe: the selected reference was disqualified |
| evt_prio_switch | input | 1 | Strobe: switched to a qualified higher-priority reference |
| evt_forced_switch | input | 1 | Strobe: reference changed by forced selection |
| mode_onehot | output | 3 | Current mode, one-hot {holdover, locked, free-run} |
| hold_entry | output | 1 | One-cycle pulse on each entry to holdover |

## Verification
The automatic path is driven through every arc, with each of the three loss events used once from locked. This shows that each event alone triggers holdover, while a lost `ref_selected` without an event does not. Events applied in free-run and a long forced holdover separate a real state change from a stuck pulse. Forced codes applied from each mode, unlisted codes, and returns to automatic from each forced mode show whether the automatic machine continues from the forced mode. Power-down asserted while locked and while a forced code is applied shows that it overrides everything else.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  localparam int CODE_W = 3;
  localparam int MODE_N = 3;

  typedef enum logic [1:0] {
    MD_FREE = 2'd0,
    MD_LOCK = 2'd1,
    MD_HOLD = 2'd2
  } mode_t;

  localparam logic [CODE_W-1:0] CODE_FREE = 3'b001;
  localparam logic [CODE_W-1:0] CODE_HOLD = 3'b010;
  localparam logic [CODE_W-1:0] CODE_LOCK = 3'b100;
endpackage

// File: rtl/pll_mode_decode.sv
module pll_mode_decode
  import pll_mode_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              forced,
  output mode_t             forced_mode
);
  always_comb begin
    forced      = 1'b1;
    forced_mode = MD_FREE;
    unique case (code)
      CODE_FREE: forced_mode = MD_FREE;
      CODE_HOLD: forced_mode = MD_HOLD;
      CODE_LOCK: forced_mode = MD_LOCK;
      default:   forced      = 1'b0;
    endcase
  end
endmodule

// File: rtl/pll_mode_next.sv
module pll_mode_next
  import pll_mode_pkg::*;
(
  input  mode_t cur,
  input  logic  forced,
  input  mode_t forced_mode,
  input  logic  ref_sel,
  input  logic  ref_loss,
  output mode_t nxt
);
  always_comb begin
    nxt = cur;
    if (forced) begin
      nxt = forced_mode;
    end else begin
      unique case (cur)
        MD_FREE: if (ref_sel) nxt = MD_LOCK;
        MD_LOCK: if (ref_loss) nxt = MD_HOLD;
        MD_HOLD: nxt = ref_sel ? MD_LOCK : MD_FREE;
        default: nxt = MD_FREE;
      endcase
    end
  end
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int N_EVT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              pwr_down,
  input  logic              ref_selected,
  input  logic              evt_disqual,
  input  logic              evt_prio_switch,
  input  logic              evt_forced_switch,
  output logic [MODE_N-1:0] mode_onehot,
  output logic              hold_entry
);
  logic [N_EVT-1:0] evt_vec;
  logic             ref_loss;
  logic             forced;
  mode_t            forced_mode;
  mode_t            state_q, state_d;
  logic             pulse_q;

  assign evt_vec  = {evt_forced_switch, evt_prio_switch, evt_disqual};
  assign ref_loss = |evt_vec;

  pll_mode_decode u_dec (
    .code        (mode_code),
    .forced      (forced),
    .forced_mode (forced_mode)
  );

  pll_mode_next u_next (
    .cur         (state_q),
    .forced      (forced),
    .forced_mode (forced_mode),
    .ref_sel     (ref_selected),
    .ref_loss    (ref_loss),
    .nxt         (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MD_FREE;
      pulse_q <= 1'b0;
    end else if (pwr_down) begin
      state_q <= MD_FREE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_d == MD_HOLD) && (state_q != MD_HOLD);
    end
  end

  for (genvar g = 0; g < MODE_N; g++) begin : g_onehot
    assign mode_onehot[g] = (state_q == mode_t'(g));
  end

  assign hold_entry = pulse_q;
endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_code,
  input logic       pwr_down,
  input logic       ref_selected,
  input logic       evt_disqual,
  input logic       evt_prio_switch,
  input logic       evt_forced_switch,
  input logic [2:0] mode_onehot,
  input logic       hold_entry
);
  logic is_auto;
  assign is_auto = (mode_code != 3'b001) && (mode_code != 3'b010) && (mode_code != 3'b100);

  a_r2_pd_free: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (mode_onehot == 3'b001) && !hold_entry);

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1);

  a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && is_auto && mode_onehot[0] && ref_selected) |=> mode_onehot[1]);

  a_r6_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && is_auto && mode_onehot[1] &&
     (evt_disqual || evt_prio_switch || evt_forced_switch)) |=> mode_onehot[2]);

  a_r9_force_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && mode_code == 3'b100) |=> mode_onehot[1]);

  a_r10_pulse_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hold_entry |-> (mode_onehot[2] && !$past(mode_onehot[2])));

  a_r10_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_onehot[2]) |-> hold_entry);
endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .mode_code         (mode_code),
  .pwr_down          (pwr_down),
  .ref_selected      (ref_selected),
  .evt_disqual       (evt_disqual),
  .evt_prio_switch   (evt_prio_switch),
  .evt_forced_switch (evt_forced_switch),
  .mode_onehot       (mode_onehot),
  .hold_entry        (hold_entry)
);

// File: tb/pll_mode_ctrl_test.sv
module pll_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_code = 3'b000;
  logic       pwr_down = 1'b1;
  logic       ref_selected = 1'b0;
  logic       evt_disqual = 1'b0;
  logic       evt_prio_switch = 1'b0;
  logic       evt_forced_switch = 1'b0;
  logic [2:0] mode_onehot;
  logic       hold_entry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int m_st = 0;
  int m_pls = 0;

  always #5 clk = ~clk;

  pll_mode_ctrl uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .mode_code         (mode_code),
    .pwr_down          (pwr_down),
    .ref_selected      (ref_selected),
    .evt_disqual       (evt_disqual),
    .evt_prio_switch   (evt_prio_switch),
    .evt_forced_switch (evt_forced_switch),
    .mode_onehot       (mode_onehot),
    .hold_entry        (hold_entry)
  );

  task automatic compare(input string tag);
    logic [2:0] exp_m;
    exp_m = 3'(1 << m_st);
    checks++;
    if (mode_onehot !== exp_m || hold_entry !== m_pls[0]) begin
      fails++;
      $display("FAIL %s: mode=%b pulse=%b expected mode=%b pulse=%0d",
               tag, mode_onehot, hold_entry, exp_m, m_pls);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] code, input logic pd,
                      input logic rs, input logic dq, input logic pr, input logic fs);
    int nst;
    mode_code = code; pwr_down = pd; ref_selected = rs;
    evt_disqual = dq; evt_prio_switch = pr; evt_forced_switch = fs;
    if (pd) nst = 0;
    else if (code == 3'b001) nst = 0;
    else if (code == 3'b010) nst = 2;
    else if (code == 3'b100) nst = 1;
    else if (m_st == 0) nst = rs ? 1 : 0;
    else if (m_st == 1) nst = (dq || pr || fs) ? 2 : 1;
    else nst = rs ? 1 : 0;
    m_pls = (nst == 2 && m_st != 2) ? 1 : 0;
    m_st = nst;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 after reset");
    // power-down default holds free-run even with reference
    step("R2 powered down", 3'b000, 1, 1, 0, 0, 0);
    step("R2 powered down forced lock", 3'b100, 1, 1, 1, 0, 0);
    // free-run ignores events
    step("R5 free with disqual", 3'b000, 0, 0, 1, 0, 0);
    step("R5 free with prio", 3'b000, 0, 0, 0, 1, 1);
    step("R4 free to locked", 3'b000, 0, 1, 0, 0, 0);
    step("R7 locked without ref", 3'b000, 0, 0, 0, 0, 0);
    step("R7 locked stays", 3'b000, 0, 0, 0, 0, 0);
    step("R6 disqual to hold R10", 3'b000, 0, 1, 1, 0, 0);
    step("R8 hold relocks", 3'b000, 0, 1, 0, 0, 0);
    step("R6 prio switch to hold", 3'b000, 0, 0, 0, 1, 0);
    step("R8 hold to free", 3'b000, 0, 0, 0, 0, 0);
    step("R4 relock", 3'b000, 0, 1, 0, 0, 0);
    step("R6 forced switch to hold", 3'b000, 0, 1, 0, 0, 1);
    step("R8 hold relock again", 3'b000, 0, 1, 0, 0, 0);
    // forced holdover from locked, held for several cycles
    step("R9 force hold R10", 3'b010, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R10 no repeat pulse", 3'b010, 0, 0, 1, 1, 1);
    step("R11 auto from forced hold", 3'b000, 0, 0, 0, 0, 0);
    step("R9 force lock", 3'b100, 0, 0, 0, 0, 0);
    step("R11 auto from forced lock", 3'b000, 0, 0, 0, 0, 0);
    step("R11 lock stays", 3'b000, 0, 0, 0, 0, 0);
    step("R9 force free", 3'b001, 0, 1, 0, 0, 0);
    step("R11 auto from forced free", 3'b000, 0, 0, 1, 0, 0);
    step("R9 force hold from free", 3'b010, 0, 0, 0, 0, 0);
    step("R11 auto from hold with ref", 3'b000, 0, 1, 0, 0, 0);
    // unlisted codes behave as automatic
    step("R9 code 011 auto event", 3'b011, 0, 1, 1, 0, 0);
    step("R9 code 101 auto", 3'b101, 0, 0, 0, 0, 0);
    step("R9 code 110 auto", 3'b110, 0, 1, 0, 0, 0);
    step("R9 code 111 auto", 3'b111, 0, 0, 0, 1, 0);
    step("R9 code 111 hold to free", 3'b111, 0, 0, 0, 0, 0);
    step("R4 relock before pd", 3'b000, 0, 1, 0, 0, 0);
    step("R2 pd from locked", 3'b000, 1, 1, 1, 0, 0);
    step("R2 pd with forced hold", 3'b010, 1, 1, 0, 0, 0);
    step("R9 force hold after pd R3", 3'b010, 0, 0, 0, 0, 0);
    step("R2 pd from hold", 3'b010, 1, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule